// File: doc/BRIEF.md
# Motor driver fault supervisor

This block decides, cycle by cycle, whether each bridge of a dual-bridge motor driver may conduct. Its inputs are a sleep request (active low), an undervoltage flag, an over-temperature flag and one raw overcurrent flag per bridge. Its outputs are one enable per bridge, an active-low fault line, a global logic reset, a regulator enable, a ready flag and a state code. The analog detectors that raise the flags are outside the block. All flag inputs must already be synchronous to `clk`.

The supervisor has two layers. A power sequencer handles undervoltage, the delayed entry into sleep and the delayed wake-up. Under it, each bridge has its own overcurrent channel. The channel filters the raw flag over a deglitch window and, after a trip, holds the bridge off for a retry window before it re-enables the bridge by itself. Nothing is latched: every fault indication clears as soon as its cause has gone. The conditions rank as follows, highest first: undervoltage, then sleep, then over-temperature, then overcurrent.

All outputs are registered. A change on an input or on internal state reaches the pins on the clock edge after the one that samples it.

Top module: `mfs_supervisor`

## Requirements
- R1: While `rst` is high, the outputs hold these values: `bridge_en_o`=0, `fault_n_o`=1, `ready_o`=0, `logic_rst_o`=0, `reg_en_o`=0, `state_o`=4 (wake). After reset, the block passes through the wake delay before it becomes ready.
- R2: The overcurrent flag of a bridge trips that bridge only if it is sampled high on `OCP_DEGLITCH` consecutive edges. A shorter pulse has no effect on `bridge_en_o` or `fault_n_o`. That bridge's enable falls one cycle after the tripping edge.
- R3: An overcurrent trip clears only the enable of the affected bridge, and pulls `fault_n_o` low. Each bridge is filtered and tripped independently, and both may trip on the same edge.
- R4: A tripped bridge stays off for `OCP_RETRY` cycles. It then re-enables automatically and `fault_n_o` is released, whatever the flag shows during the retry window.
- R5: While `ot_i` is high during operation, both enables are low and `fault_n_o` is low. Both are restored one cycle after `ot_i` clears.
- R6: While `uv_i` is high: both enables are low, `logic_rst_o` is high, `reg_en_o` is low and `fault_n_o` is low. `state_o` reads 0. Any pending overcurrent trip is discarded. When `uv_i` clears, the block runs the wake delay and then resumes.
- R7: `state_o` reaches 3 (sleep) `SLEEP_DELAY` cycles after `sleep_n_i` is first sampled low. The bridges keep operating until then. In sleep, both enables and `reg_en_o` are low.
- R8: After `sleep_n_i` is sampled high in sleep, `state_o` reads 4 (wake) and the enables stay low for `WAKE_DELAY` cycles. After that, `state_o` reads 1 (run) and the bridges are enabled. If `sleep_n_i` returns high before the sleep delay ends, the sleep entry is cancelled with no interruption.
- R9: Sleep masks over-temperature and overcurrent: neither pulls `fault_n_o` low while the block sleeps. Whenever `ready_o` is high, `reg_en_o` is high and `logic_rst_o` is low.
- R10: `fault_n_o` goes high only when no fault source remains active. A bridge still in its retry window keeps it low after over-temperature has cleared.
- R11: `state_o` encodes 0 undervoltage, 1 run, 2 sleep pending, 3 sleep, 4 wake. No other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_n_i | input | 1 | Sleep request, low asks for sleep |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| oc_raw_i | input | NB | Raw overcurrent flag per bridge |
| bridge_en_o | output | NB | Bridge enable per bridge, low means high impedance |
| fault_n_o | output | 1 | Fault indication, active low, unlatched |
| ready_o | output | 1 | Bridges may be driven (run or sleep pending) |
| state_o | output | 3 | Power state code |
| logic_rst_o | output | 1 | Global logic reset during undervoltage |
| reg_en_o | output | 1 | Internal regulator enable |

## Verification
Three pairs of events can land in the same cycle. Over-temperature can clear while one bridge is still counting down its retry window. Both bridges can trip on the same edge. Undervoltage can arrive while a trip is pending. The bench provokes the first case by tripping bridge 1, raising and dropping the temperature flag within the retry window, and then checking that the fault line stays low until the retry expires. For the second case it drives both overcurrent flags together and checks that both enables drop on the same cycle and return on the same cycle. For the third it raises undervoltage during a trip and checks that the tripped bridge comes back as soon as the wake delay ends, not after the retry.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [2:0] {
    ST_UV         = 3'd0,
    ST_RUN        = 3'd1,
    ST_SLEEP_PEND = 3'd2,
    ST_SLEEP      = 3'd3,
    ST_WAKE       = 3'd4
  } pwr_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mfs_power_seq.sv
module mfs_power_seq
  import mfs_pkg::*;
#(
  parameter int SLEEP_DELAY = 200,
  parameter int WAKE_DELAY  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_n_i,
  input  logic       uv_i,
  output pwr_state_e st_o
);

  localparam int CNT_MAX = max2(SLEEP_DELAY, WAKE_DELAY);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_DELAY - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_DELAY - 1);

  pwr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_WAKE;
      cnt_q <= '0;
    end else if (uv_i) begin
      st_q  <= ST_UV;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_UV: begin
          st_q  <= ST_WAKE;
          cnt_q <= '0;
        end
        ST_RUN: begin
          if (!sleep_n_i) begin
            st_q  <= ST_SLEEP_PEND;
            cnt_q <= '0;
          end
        end
        ST_SLEEP_PEND: begin
          if (sleep_n_i) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else if (cnt_q == SLEEP_LAST) begin
            st_q  <= ST_SLEEP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (sleep_n_i) begin
            st_q  <= ST_WAKE;
            cnt_q <= '0;
          end
        end
        ST_WAKE: begin
          if (!sleep_n_i) begin
            st_q  <= ST_SLEEP_PEND;
            cnt_q <= '0;
          end else if (cnt_q == WAKE_LAST) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_WAKE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/mfs_oc_channel.sv
module mfs_oc_channel
  import mfs_pkg::*;
#(
  parameter int OCP_DEGLITCH = 16,
  parameter int OCP_RETRY    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic oc_i,
  output logic trip_o
);

  localparam int CNT_MAX = max2(OCP_DEGLITCH, OCP_RETRY);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] DG_LAST = CW'(OCP_DEGLITCH - 1);
  localparam logic [CW-1:0] RT_LAST = CW'(OCP_RETRY - 1);

  logic          trip_q;
  logic [CW-1:0] cnt_q;

  // Counter is shared: it counts high samples while armed and retry cycles while tripped.
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      trip_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!trip_q) begin
      if (oc_i) begin
        if (cnt_q == DG_LAST) begin
          trip_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end else begin
      if (cnt_q == RT_LAST) begin
        trip_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign trip_o = trip_q;

endmodule

// File: rtl/mfs_supervisor.sv
module mfs_supervisor
  import mfs_pkg::*;
#(
  parameter int NB           = 2,
  parameter int OCP_DEGLITCH = 16,
  parameter int OCP_RETRY    = 1000,
  parameter int SLEEP_DELAY  = 200,
  parameter int WAKE_DELAY   = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_n_i,
  input  logic          uv_i,
  input  logic          ot_i,
  input  logic [NB-1:0] oc_raw_i,
  output logic [NB-1:0] bridge_en_o,
  output logic          fault_n_o,
  output logic          ready_o,
  output logic [2:0]    state_o,
  output logic          logic_rst_o,
  output logic          reg_en_o
);

  pwr_state_e    pwr_st;
  logic          run;
  logic          uv_any;
  logic [NB-1:0] trip;

  mfs_power_seq #(
    .SLEEP_DELAY(SLEEP_DELAY),
    .WAKE_DELAY (WAKE_DELAY)
  ) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .sleep_n_i(sleep_n_i),
    .uv_i     (uv_i),
    .st_o     (pwr_st)
  );

  assign uv_any = uv_i || (pwr_st == ST_UV);
  assign run    = !uv_i && ((pwr_st == ST_RUN) || (pwr_st == ST_SLEEP_PEND));

  for (genvar b = 0; b < NB; b++) begin : g_oc
    mfs_oc_channel #(
      .OCP_DEGLITCH(OCP_DEGLITCH),
      .OCP_RETRY   (OCP_RETRY)
    ) u_chan (
      .clk   (clk),
      .rst   (rst),
      .run_i (run),
      .oc_i  (oc_raw_i[b]),
      .trip_o(trip[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bridge_en_o <= '0;
      fault_n_o   <= 1'b1;
      ready_o     <= 1'b0;
      state_o     <= ST_WAKE;
      logic_rst_o <= 1'b0;
      reg_en_o    <= 1'b0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        bridge_en_o[b] <= run && !ot_i && !trip[b];
      end
      fault_n_o   <= !(uv_any || (run && (ot_i || (|trip))));
      ready_o     <= run;
      state_o     <= pwr_st;
      logic_rst_o <= uv_any;
      reg_en_o    <= !(uv_any || (pwr_st == ST_SLEEP));
    end
  end

endmodule

// File: rtl/mfs_supervisor_chk.sv
module mfs_supervisor_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          uv_i,
  input logic          ot_i,
  input logic [NB-1:0] oc_raw_i,
  input logic [NB-1:0] bridge_en_o,
  input logic          fault_n_o,
  input logic          ready_o,
  input logic [2:0]    state_o,
  input logic          logic_rst_o,
  input logic          reg_en_o
);

  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R6: undervoltage shuts everything down on the next cycle
  assert_uv_shutdown_R6: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && $past(uv_i)) |->
      (bridge_en_o == '0 && logic_rst_o && !reg_en_o && !fault_n_o));

  // R5: over-temperature blocks both bridges
  assert_ot_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && $past(ot_i)) |-> (bridge_en_o == '0));

  // R7: sleep state implies regulator and bridges off
  assert_sleep_off_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> (!reg_en_o && bridge_en_o == '0));

  // R9: ready implies regulator on and no logic reset
  assert_ready_clean_R9: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (reg_en_o && !logic_rst_o));

  // R11: only legal state codes
  assert_state_legal_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o <= 3'd4));

  // R2: a bridge drop while operating and cool needs a high overcurrent sample
  for (genvar b = 0; b < NB; b++) begin : g_oc_chk
    assert_oc_cause_R2: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && $fell(bridge_en_o[b]) && ready_o && !$past(ot_i)) |->
        $past(oc_raw_i[b], 2));
  end

endmodule

bind mfs_supervisor mfs_supervisor_chk #(.NB(NB)) u_mfs_chk (
  .clk        (clk),
  .rst        (rst),
  .uv_i       (uv_i),
  .ot_i       (ot_i),
  .oc_raw_i   (oc_raw_i),
  .bridge_en_o(bridge_en_o),
  .fault_n_o  (fault_n_o),
  .ready_o    (ready_o),
  .state_o    (state_o),
  .logic_rst_o(logic_rst_o),
  .reg_en_o   (reg_en_o)
);

// File: tb/mfs_supervisor_bench.sv
`timescale 1ns/1ps
module mfs_supervisor_bench;

  localparam int NB = 2;
  localparam int DG = 4;
  localparam int RT = 12;
  localparam int SL = 6;
  localparam int WK = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          sleep_n;
  logic          uv;
  logic          ot;
  logic [NB-1:0] oc;
  logic [NB-1:0] en;
  logic          fault_n;
  logic          ready;
  logic [2:0]    state;
  logic          lrst;
  logic          reg_en;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  mfs_supervisor #(
    .NB(NB), .OCP_DEGLITCH(DG), .OCP_RETRY(RT),
    .SLEEP_DELAY(SL), .WAKE_DELAY(WK)
  ) u_mfs_supervisor (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n), .uv_i(uv), .ot_i(ot),
    .oc_raw_i(oc), .bridge_en_o(en), .fault_n_o(fault_n), .ready_o(ready),
    .state_o(state), .logic_rst_o(lrst), .reg_en_o(reg_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance n rising edges and land on the following falling edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; sleep_n = 1'b1; uv = 1'b0; ot = 1'b0; oc = '0;
    tick(3);
    chk("R1", "en", en, 0);
    chk("R1", "fault_n", fault_n, 1);
    chk("R1", "ready", ready, 0);
    chk("R1", "state", state, 4);
    chk("R1", "logic_rst", lrst, 0);
    chk("R1", "reg_en", reg_en, 0);
    rst = 1'b0;
    tick(WK + 3);
    chk("R1", "ready after wake", ready, 1);
    chk("R11", "run code", state, 1);
    chk("R1", "en after wake", en, 3);
  endtask

  task automatic t_glitch;
    oc = 2'b01;
    tick(DG - 1);
    oc = '0;
    tick(DG + 2);
    chk("R2", "short pulse en", en, 3);
    chk("R2", "short pulse fault", fault_n, 1);
  endtask

  task automatic t_trip_retry;
    oc = 2'b01;
    tick(DG);
    chk("R2", "en before deglitch end", en, 3);
    tick(1);
    chk("R3", "only bridge0 off", en, 2'b10);
    chk("R3", "fault low", fault_n, 0);
    oc = '0;
    tick(RT - 1);
    chk("R4", "still off in retry", en, 2'b10);
    tick(1);
    chk("R4", "re-enabled", en, 3);
    chk("R4", "fault released", fault_n, 1);
  endtask

  task automatic t_both_trip;
    oc = 2'b11;
    tick(DG + 1);
    chk("R3", "both off same cycle", en, 0);
    oc = '0;
    tick(RT);
    chk("R3", "both back same cycle", en, 3);
  endtask

  task automatic t_overtemp;
    ot = 1'b1;
    tick(1);
    chk("R5", "ot en", en, 0);
    chk("R5", "ot fault", fault_n, 0);
    ot = 1'b0;
    tick(1);
    chk("R5", "ot release en", en, 3);
    chk("R5", "ot release fault", fault_n, 1);
  endtask

  task automatic t_overlap;
    oc = 2'b10;
    tick(DG + 1);
    chk("R3", "bridge1 off", en, 2'b01);
    oc = '0;
    ot = 1'b1;
    tick(1);
    chk("R5", "ot on top of trip", en, 0);
    ot = 1'b0;
    tick(1);
    chk("R10", "fault held by retry", fault_n, 0);
    chk("R10", "bridge0 back", en, 2'b01);
    tick(RT - 3);
    chk("R10", "fault still held", fault_n, 0);
    tick(1);
    chk("R10", "fault released", fault_n, 1);
    chk("R10", "both on", en, 3);
  endtask

  task automatic t_undervoltage;
    oc = 2'b01;
    tick(DG + 1);
    oc = '0;
    uv = 1'b1;
    tick(1);
    chk("R6", "uv en", en, 0);
    chk("R6", "uv logic_rst", lrst, 1);
    chk("R6", "uv reg_en", reg_en, 0);
    chk("R6", "uv fault", fault_n, 0);
    tick(1);
    chk("R6", "uv state", state, 0);
    uv = 1'b0;
    tick(2);
    chk("R6", "logic_rst released", lrst, 0);
    chk("R8", "wake code", state, 4);
    chk("R6", "en off in wake", en, 0);
    tick(WK);
    chk("R6", "trip discarded", en, 3);
    chk("R6", "fault after uv", fault_n, 1);
  endtask

  task automatic t_sleep_wake;
    sleep_n = 1'b0;
    tick(2);
    chk("R11", "pending code", state, 2);
    tick(SL - 1);
    chk("R7", "still driving", en, 3);
    tick(1);
    chk("R7", "sleep en", en, 0);
    chk("R7", "sleep reg", reg_en, 0);
    chk("R7", "sleep code", state, 3);
    ot = 1'b1; oc = 2'b11;
    tick(DG + 3);
    chk("R9", "ot masked in sleep", fault_n, 1);
    chk("R9", "still off", en, 0);
    ot = 1'b0; oc = '0;
    sleep_n = 1'b1;
    tick(2);
    chk("R8", "wake code", state, 4);
    chk("R8", "regulator on", reg_en, 1);
    tick(WK - 1);
    chk("R8", "off in wake delay", en, 0);
    tick(1);
    chk("R8", "on after wake", en, 3);
    chk("R11", "run code", state, 1);
  endtask

  task automatic t_abort;
    sleep_n = 1'b0;
    tick(2);
    sleep_n = 1'b1;
    tick(SL + 3);
    chk("R8", "abort keeps en", en, 3);
    chk("R8", "abort back to run", state, 1);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_trip_retry();
    t_both_trip();
    t_overtemp();
    t_overlap();
    t_undervoltage();
    t_sleep_wake();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule